// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block sits at the issue point of a statically scheduled two-wide pipeline. Each cycle the fetch stage may offer one 8-byte-aligned packet with two 32-bit instruction words. Slot 0 is reserved for arithmetic or branch work. Slot 1 is reserved for memory access. Either slot may carry a nop. The checker first decodes both words. It then confirms that each word suits its slot and that the packet address is aligned. It rejects a packet whose memory instruction needs the arithmetic result produced in the same packet, because forwarding cannot deliver that value in time.

The checker also keeps the destination of a load issued in the previous cycle. If the packet now on offer reads that register, the packet is held for one cycle: ready to fetch is dropped, and an all-nop bubble packet goes downstream with a stall flag. The load record is then cleared, so the held packet issues on the next cycle. Results that pass between packets from arithmetic instructions are left to forwarding and never stall. Every output is registered, so a decision appears one clock after the packet is presented.

Top module: `dual_issue_checker`

## Requirements
- R1: While reset is high and after it, with no packet offered, out_valid, out_stall, out_err_slot and out_err_dep are 0 and in_ready is 1.
- R2: A legal packet with no hazard is accepted (in_ready=1). One cycle later out_valid=1 and out_slot0/out_slot1 equal the two words unchanged.
- R3: Decode uses opcode bits [31:26]. The all-zero word is a nop. Opcode 0 (nonzero word) and opcodes 0x08..0x0F are arithmetic. Opcodes 0x04/0x05 are branches. 0x20..0x25 are loads. 0x28..0x2B are stores. Every other opcode is illegal. Slot 0 accepts only nop, arithmetic or branch. Slot 1 accepts only nop, load or store. A violation gives out_err_slot=1 and out_valid=0 one cycle later, and the packet is consumed.
- R4: A packet address whose low three bits are not zero gives out_err_slot=1 and out_valid=0.
- R5: If slot 1 reads the register written by slot 0, the packet gives out_err_dep=1 and out_valid=0 and is consumed. Slot 0 writes bits [15:11] for opcode 0 and bits [20:16] for 0x08..0x0F. Slot 1 reads base bits [25:21], and also bits [20:16] for a store.
- R6: A load issued in slot 1 writes bits [20:16]. If the packet offered in the very next cycle reads that register in either slot, in_ready=0. One cycle later out_valid=1, out_stall=1 and both out slots are zero. Slot 0 reads bits [25:21] and [20:16] for opcode 0 and branches, and bits [25:21] for 0x08..0x0F.
- R7: A packet held by a load-use stall issues on the following cycle without a second stall.
- R8: Register 0 never creates an intra-packet or a load-use dependency.
- R9: Arithmetic results consumed by the next packet cause no stall. A load followed by an idle cycle causes no stall either.
- R10: When a packet has both a load-use hazard and an intra-packet dependency, the stall comes first. The dependency error is reported when the held packet is examined again.
- R11: An illegal packet is never held, even if it also reads the pending load's destination. It is consumed with out_err_slot=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch offers a packet |
| in_ready | output | 1 | Packet is taken this cycle |
| in_addr | input | 32 | Byte address of the packet |
| in_slot0 | input | 32 | Arithmetic/branch slot word |
| in_slot1 | input | 32 | Load/store slot word |
| out_valid | output | 1 | A packet (or bubble) goes downstream |
| out_slot0 | output | 32 | Issued slot 0 word |
| out_slot1 | output | 32 | Issued slot 1 word |
| out_stall | output | 1 | Issued packet is a load-use bubble |
| out_err_slot | output | 1 | Packet rejected: slot role or alignment |
| out_err_dep | output | 1 | Packet rejected: same-packet dependency |

## Verification
The load-use stall can coincide with either rejection in the same cycle. The bench provokes this by issuing a load and then offering a packet that both reads the loaded register and breaks a second rule. In one case the second rule is a same-packet dependency. In the other it is misalignment. For the dependency case, the stall and bubble must appear first and the dependency error on the retry. For the misalignment case, there must be no hold at all and the slot error must appear at once.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int REG_W = 5;

  typedef enum logic [2:0] {
    K_NOP, K_ALU, K_BR, K_LD, K_ST, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic             rd_a;
    logic             rd_b;
  } dinfo_t;

  function automatic logic reads_reg(input dinfo_t d, input logic [REG_W-1:0] r);
    return (r != '0) && ((d.rd_a && d.src_a == r) || (d.rd_b && d.src_b == r));
  endfunction
endpackage

// File: rtl/dic_decode.sv
module dic_decode
  import dic_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output dinfo_t             info
);
  localparam int OP_HI = INSTR_W - 1;
  localparam int OP_LO = INSTR_W - 6;
  localparam int RS_LO = OP_LO - REG_W;
  localparam int RT_LO = RS_LO - REG_W;
  localparam int RD_LO = RT_LO - REG_W;

  logic [5:0]       op;
  logic [REG_W-1:0] rs, rt, rd;
  logic             unused_low;

  assign op = instr[OP_HI:OP_LO];
  assign rs = instr[OP_LO-1:RS_LO];
  assign rt = instr[RS_LO-1:RT_LO];
  assign rd = instr[RT_LO-1:RD_LO];
  assign unused_low = ^instr[RD_LO-1:0];

  always_comb begin
    info = '{kind: K_BAD, dst: '0, src_a: rs, src_b: rt, rd_a: 1'b0, rd_b: 1'b0};
    if (instr == '0) begin
      info.kind = K_NOP;
    end else if (op == 6'h00) begin
      info.kind = K_ALU; info.dst = rd; info.rd_a = 1'b1; info.rd_b = 1'b1;
    end else if (op == 6'h04 || op == 6'h05) begin
      info.kind = K_BR; info.rd_a = 1'b1; info.rd_b = 1'b1;
    end else if (op inside {[6'h08:6'h0F]}) begin
      info.kind = K_ALU; info.dst = rt; info.rd_a = 1'b1;
    end else if (op inside {[6'h20:6'h25]}) begin
      info.kind = K_LD; info.dst = rt; info.rd_a = 1'b1;
    end else if (op inside {[6'h28:6'h2B]}) begin
      info.kind = K_ST; info.rd_a = 1'b1; info.rd_b = 1'b1;
    end
  end
endmodule

// File: rtl/dic_hazard.sv
module dic_hazard
  import dic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  dinfo_t            d0,
  input  dinfo_t            d1,
  input  logic              prev_vld,
  input  logic [REG_W-1:0]  prev_dst,
  output logic              illegal,
  output logic              intra,
  output logic              loaduse
);
  logic slot0_ok, slot1_ok, misaligned;
  logic unused_addr;

  assign unused_addr = ^addr[ADDR_W-1:ALIGN_BITS];
  assign misaligned  = addr[ALIGN_BITS-1:0] != '0;
  assign slot0_ok    = d0.kind inside {K_NOP, K_ALU, K_BR};
  assign slot1_ok    = d1.kind inside {K_NOP, K_LD, K_ST};
  assign illegal     = misaligned || !slot0_ok || !slot1_ok;
  assign intra       = reads_reg(d1, d0.dst);
  assign loaduse     = prev_vld && (reads_reg(d0, prev_dst) || reads_reg(d1, prev_dst));
endmodule

// File: rtl/dual_issue_checker.sv
module dual_issue_checker
  import dic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [INSTR_W-1:0] in_slot0,
  input  logic [INSTR_W-1:0] in_slot1,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_slot0,
  output logic [INSTR_W-1:0] out_slot1,
  output logic               out_stall,
  output logic               out_err_slot,
  output logic               out_err_dep
);
  localparam int SLOTS = 2;

  logic [INSTR_W-1:0] words [SLOTS];
  dinfo_t             dec   [SLOTS];
  logic               hz_illegal, hz_intra, hz_loaduse;
  logic               prev_vld;
  logic [REG_W-1:0]   prev_dst;

  assign words[0] = in_slot0;
  assign words[1] = in_slot1;

  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    dic_decode #(.INSTR_W(INSTR_W)) i_dec (.instr(words[g]), .info(dec[g]));
  end

  dic_hazard #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) i_hz (
    .addr(in_addr), .d0(dec[0]), .d1(dec[1]),
    .prev_vld(prev_vld), .prev_dst(prev_dst),
    .illegal(hz_illegal), .intra(hz_intra), .loaduse(hz_loaduse)
  );

  assign in_ready = !(in_valid && hz_loaduse && !hz_illegal);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_slot0    <= '0;
      out_slot1    <= '0;
      out_stall    <= 1'b0;
      out_err_slot <= 1'b0;
      out_err_dep  <= 1'b0;
      prev_vld     <= 1'b0;
      prev_dst     <= '0;
    end else begin
      out_valid    <= 1'b0;
      out_slot0    <= '0;
      out_slot1    <= '0;
      out_stall    <= 1'b0;
      out_err_slot <= 1'b0;
      out_err_dep  <= 1'b0;
      prev_vld     <= 1'b0;
      if (in_valid) begin
        if (hz_illegal) begin
          out_err_slot <= 1'b1;
        end else if (hz_loaduse) begin
          out_valid <= 1'b1;
          out_stall <= 1'b1;
        end else if (hz_intra) begin
          out_err_dep <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_slot0 <= in_slot0;
          out_slot1 <= in_slot1;
          prev_vld  <= (dec[1].kind == K_LD) && (dec[1].dst != '0);
          prev_dst  <= dec[1].dst;
        end
      end
    end
  end

  a_r3_reject_no_issue: assert property (@(posedge clk) disable iff (rst)
    out_err_slot |-> !out_valid && !out_err_dep);
  a_r5_dep_no_issue: assert property (@(posedge clk) disable iff (rst)
    out_err_dep |-> !out_valid && !out_stall);
  a_r6_bubble_empty: assert property (@(posedge clk) disable iff (rst)
    out_stall |-> out_valid && out_slot0 == '0 && out_slot1 == '0);
  a_r6_hold_gives_stall: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> out_stall);
  a_r7_single_stall: assert property (@(posedge clk) disable iff (rst)
    out_stall |=> !out_stall);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_err_slot && !out_err_dep);
endmodule

// File: tb/test_dual_issue_checker.sv
module test_dual_issue_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [31:0] in_slot0 = '0;
  logic [31:0] in_slot1 = '0;
  logic        out_valid, out_stall, out_err_slot, out_err_dep;
  logic [31:0] out_slot0, out_slot1;
  logic        rdy;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  dual_issue_checker i_dual_issue_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_slot0(in_slot0), .in_slot1(in_slot1),
    .out_valid(out_valid), .out_slot0(out_slot0), .out_slot1(out_slot1),
    .out_stall(out_stall), .out_err_slot(out_err_slot), .out_err_dep(out_err_dep)
  );

  function automatic logic [31:0] alu_r(input int rs, rt, rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] alu_i(input int rs, rt);
    return {6'h08, 5'(rs), 5'(rt), 16'h0004};
  endfunction
  function automatic logic [31:0] ld(input int base, dst);
    return {6'h23, 5'(base), 5'(dst), 16'h0000};
  endfunction
  function automatic logic [31:0] st(input int base, data);
    return {6'h2B, 5'(base), 5'(data), 16'h0000};
  endfunction
  function automatic logic [31:0] br(input int rs, rt);
    return {6'h04, 5'(rs), 5'(rt), 16'h0010};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] s0, input logic [31:0] s1);
    in_valid = 1'b1; in_addr = a; in_slot0 = s0; in_slot1 = s1;
    #1 rdy = in_ready;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic expect_issue(input string req, input logic [31:0] s0, input logic [31:0] s1);
    chk({req, " ready"}, 32'(rdy), 32'd1);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " stall"}, 32'(out_stall), 32'd0);
    chk({req, " slot0"}, out_slot0, s0);
    chk({req, " slot1"}, out_slot1, s1);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 stall", 32'(out_stall), 32'd0);
    chk("R1 errors", {30'd0, out_err_slot, out_err_dep}, 32'd0);
    chk("R1 ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_legal();
    idle();
    send(32'h100, alu_r(1, 2, 3), ld(5, 4));
    expect_issue("R2 alu+load", alu_r(1, 2, 3), ld(5, 4));
    idle();
    send(32'h108, br(3, 4), 32'h0);
    expect_issue("R3 branch+nop", br(3, 4), 32'h0);
    send(32'h110, 32'h0, st(2, 7));
    expect_issue("R2 nop+store", 32'h0, st(2, 7));
  endtask

  task automatic t_roles();
    idle();
    send(32'h200, ld(1, 2), alu_r(1, 2, 3));
    chk("R3 swapped ready", 32'(rdy), 32'd1);
    chk("R3 swapped err", 32'(out_err_slot), 32'd1);
    chk("R3 swapped valid", 32'(out_valid), 32'd0);
    send(32'h208, 32'h0, br(1, 2));
    chk("R3 branch in slot1", 32'(out_err_slot), 32'd1);
    send(32'h210, {6'h3F, 26'h1}, 32'h0);
    chk("R3 unknown opcode", 32'(out_err_slot), 32'd1);
    send(32'h104, alu_r(1, 2, 3), ld(5, 4));
    chk("R4 misaligned err", 32'(out_err_slot), 32'd1);
    chk("R4 misaligned valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_intra();
    idle();
    send(32'h300, alu_i(1, 6), st(7, 6));
    chk("R5 store data dep", 32'(out_err_dep), 32'd1);
    chk("R5 no issue", 32'(out_valid), 32'd0);
    send(32'h308, alu_r(1, 2, 9), ld(9, 4));
    chk("R5 base dep", 32'(out_err_dep), 32'd1);
    chk("R5 ready", 32'(rdy), 32'd1);
    send(32'h310, alu_i(1, 0), ld(0, 4));
    chk("R8 r0 intra", 32'(out_err_dep), 32'd0);
    expect_issue("R8 r0 intra", alu_i(1, 0), ld(0, 4));
  endtask

  task automatic t_loaduse();
    idle();
    send(32'h400, 32'h0, ld(9, 8));
    send(32'h408, alu_r(8, 1, 10), 32'h0);
    chk("R6 ready low", 32'(rdy), 32'd0);
    chk("R6 stall", 32'(out_stall), 32'd1);
    chk("R6 bubble valid", 32'(out_valid), 32'd1);
    chk("R6 bubble slots", out_slot0 | out_slot1, 32'd0);
    send(32'h408, alu_r(8, 1, 10), 32'h0);
    expect_issue("R7 retry", alu_r(8, 1, 10), 32'h0);
    idle();
    send(32'h410, 32'h0, ld(9, 8));
    send(32'h418, 32'h0, st(8, 2));
    chk("R6 base use", 32'(out_stall), 32'd1);
    send(32'h418, 32'h0, st(8, 2));
    expect_issue("R7 store retry", 32'h0, st(8, 2));
  endtask

  task automatic t_nostall();
    idle();
    send(32'h500, 32'h0, ld(9, 0));
    send(32'h508, alu_r(0, 0, 10), 32'h0);
    expect_issue("R8 r0 load", alu_r(0, 0, 10), 32'h0);
    send(32'h510, alu_r(1, 2, 11), 32'h0);
    send(32'h518, alu_r(11, 11, 12), ld(11, 12));
    expect_issue("R9 forwarded", alu_r(11, 11, 12), ld(11, 12));
    idle();
    send(32'h520, 32'h0, ld(9, 8));
    idle();
    send(32'h528, alu_r(8, 8, 13), 32'h0);
    expect_issue("R9 gap", alu_r(8, 8, 13), 32'h0);
  endtask

  task automatic t_overlap();
    idle();
    send(32'h600, 32'h0, ld(9, 8));
    send(32'h608, alu_i(8, 13), st(13, 2));
    chk("R10 stall first", 32'(out_stall), 32'd1);
    chk("R10 no dep yet", 32'(out_err_dep), 32'd0);
    send(32'h608, alu_i(8, 13), st(13, 2));
    chk("R10 dep on retry", 32'(out_err_dep), 32'd1);
    chk("R10 no second stall", 32'(out_stall), 32'd0);
    idle();
    send(32'h610, 32'h0, ld(9, 8));
    send(32'h61C, alu_r(8, 1, 10), 32'h0);
    chk("R11 ready", 32'(rdy), 32'd1);
    chk("R11 err", 32'(out_err_slot), 32'd1);
    chk("R11 no stall", 32'(out_stall), 32'd0);
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_legal();
    t_roles();
    t_intra();
    t_loaduse();
    t_nostall();
    t_overlap();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule